// File: doc/BRIEF.md
# eMMC Power-Up Initialization Sequencer

This block walks a freshly powered eMMC device to the point where block transfers are allowed. It does not drive the command line itself. It asks a separate command engine for one command at a time, giving the command index, the 32-bit argument and the kind of response to expect. It then waits for that engine to report completion with a response payload, a timeout flag and a CRC-error flag. The fixed order is: software reset (CMD0), operating-condition polling (CMD1, repeated), identification (CMD2), relative address assignment (CMD3), and selection (CMD7).

The operating-condition register returned by the final successful poll, the 128-bit identification word and the relative address given to the device are held in registers and driven on output ports. A start pulse begins the sequence. When it ends, either `ready_o` is raised in the transfer state, or `fail_o` is raised with a code naming the step that failed. Both outputs hold until the next start.

States: `ST_IDLE`, `ST_RST_SEND`/`ST_RST_WAIT` (reset), `ST_OCR_SEND`/`ST_OCR_WAIT` (polling), `ST_CID_SEND`/`ST_CID_WAIT` (identification), `ST_RCA_SEND`/`ST_RCA_WAIT` (address), `ST_SEL_SEND`/`ST_SEL_WAIT` (selection), `ST_XFER` (done) and `ST_FAIL`.

Transitions:
- Start moves `ST_IDLE`, `ST_XFER` or `ST_FAIL` to `ST_RST_SEND`.
- Each SEND state moves to its WAIT state after one cycle.
- A completion in a WAIT state moves to the next SEND state.
- From `ST_OCR_WAIT`, a completion without timeout and with bit 31 set goes on to `ST_CID_SEND`. Any other completion returns to `ST_OCR_SEND`, or goes to `ST_FAIL` if the attempt budget is spent.
- A timeout or CRC error in `ST_CID_WAIT`, `ST_RCA_WAIT` or `ST_SEL_WAIT` goes to `ST_FAIL`.
- A clean completion in `ST_SEL_WAIT` goes to `ST_XFER`.

Top module: `emmc_init_seq`

## Requirements
- R1: After reset, all of the following are 0: `ready_o`, `fail_o`, `err_code_o`, `cmd_req_o`, `ocr_o`, `cid_o` and `rca_o`. No command is requested until a start pulse arrives.
- R2: A start accepted in idle, transfer or failed state clears the stored OCR, CID, address and error code. The first request is then index 0 with argument 0 and response kind 0 (none). Its flags are ignored.
- R3: Each poll request is index 1 with argument `OCR_ARG` (default 0x40FF8080) and response kind 3 (short, no CRC). The poll is repeated while the reply has bit 31 clear or times out.
- R4: If `MAX_POLL` consecutive poll attempts all fail to show bit 31 set, the block enters the failed state with error code 1. No more requests are issued.
- R5: A poll reply without timeout that has bit 31 set is stored on `ocr_o`. The next request is then index 2, argument 0, response kind 2 (long).
- R6: A clean identification reply stores the 128-bit payload on `cid_o`. It is followed by index 3 with argument {`RCA`,16'h0000} and response kind 1 (short with CRC).
- R7: A clean address reply sets `rca_o` to `RCA` (default 1). It is followed by index 7 with argument {`RCA`,16'h0000} and response kind 1. A clean selection reply raises `ready_o`.
- R8: A timeout or CRC error on index 2, 3 or 7 raises `fail_o` with error code 2, 3 or 4 respectively. No more requests are issued.
- R9: The CRC flag on a poll reply has no effect on the poll decision.
- R10: `ready_o` and `fail_o` each hold until the next accepted start. A start pulse while the sequence is running is ignored.
- R11: `cmd_req_o` is a single-cycle pulse, and at most one request is outstanding. A completion strobe when no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin (or restart) the sequence |
| cmd_req_o | output | 1 | One-cycle command request pulse |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_rsp_o | output | 2 | Expected response: 0 none, 1 short+CRC, 2 long, 3 short no CRC |
| rsp_done_i | input | 1 | Command engine finished the outstanding command |
| rsp_timeout_i | input | 1 | No response arrived (valid with done) |
| rsp_crc_err_i | input | 1 | Response CRC mismatch (valid with done) |
| rsp_data_i | input | 128 | Response payload; short responses use bits [31:0] |
| ready_o | output | 1 | Device is in transfer state |
| fail_o | output | 1 | Sequence aborted |
| err_code_o | output | 3 | 0 none, 1 poll budget spent, 2 identify, 3 address, 4 select |
| ocr_o | output | 32 | Last ready operating-condition word |
| cid_o | output | 128 | Identification word |
| rca_o | output | 16 | Assigned relative address |

## Verification
Assertions check the following on every cycle:
- the single-cycle request pulse;
- that ready and failure are never both raised, and that each holds without a start;
- a non-zero error code whenever failure is shown;
- a ready OCR word and the programmed address whenever ready is shown;
- the poll counter staying within its budget.

Only the bench scenarios can show the following:
- the exact order and content of the requests;
- the handling of busy and timed-out polls, including the last-attempt boundary;
- the step-specific error codes;
- that CRC flags on polls are ignored;
- that stray starts and stray completions leave the sequence unchanged.

// File: rtl/emmc_init_pkg.sv
package emmc_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_SEND,
        ST_RST_WAIT,
        ST_OCR_SEND,
        ST_OCR_WAIT,
        ST_CID_SEND,
        ST_CID_WAIT,
        ST_RCA_SEND,
        ST_RCA_WAIT,
        ST_SEL_SEND,
        ST_SEL_WAIT,
        ST_XFER,
        ST_FAIL
    } seq_state_e;

    localparam logic [1:0] RSP_NONE = 2'd0;
    localparam logic [1:0] RSP_R1   = 2'd1;
    localparam logic [1:0] RSP_R2   = 2'd2;
    localparam logic [1:0] RSP_R3   = 2'd3;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_OCR  = 3'd1;
    localparam logic [2:0] ERR_CID  = 3'd2;
    localparam logic [2:0] ERR_RCA  = 3'd3;
    localparam logic [2:0] ERR_SEL  = 3'd4;

    localparam logic [5:0] IDX_RST = 6'd0;
    localparam logic [5:0] IDX_OCR = 6'd1;
    localparam logic [5:0] IDX_CID = 6'd2;
    localparam logic [5:0] IDX_RCA = 6'd3;
    localparam logic [5:0] IDX_SEL = 6'd7;

    function automatic logic [31:0] addr_arg(input logic [15:0] a);
        return {a, 16'h0000};
    endfunction

endpackage

// File: rtl/emmc_poll_ctr.sv
module emmc_poll_ctr #(
    parameter int MAX_POLL = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CNT_W = (MAX_POLL < 2) ? 1 : $clog2(MAX_POLL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLL - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // attempt in progress is the final permitted one
    assign last_o = (cnt_q == LAST);

    a_r4_cnt_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/emmc_id_regs.sv
module emmc_id_regs (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         ld_ocr_i,
    input  logic         ld_cid_i,
    input  logic         ld_rca_i,
    input  logic [31:0]  ocr_d_i,
    input  logic [127:0] cid_d_i,
    input  logic [15:0]  rca_d_i,
    output logic [31:0]  ocr_o,
    output logic [127:0] cid_o,
    output logic [15:0]  rca_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocr_o <= '0;
            cid_o <= '0;
            rca_o <= '0;
        end else if (clr_i) begin
            ocr_o <= '0;
            cid_o <= '0;
            rca_o <= '0;
        end else begin
            if (ld_ocr_i) ocr_o <= ocr_d_i;
            if (ld_cid_i) cid_o <= cid_d_i;
            if (ld_rca_i) rca_o <= rca_d_i;
        end
    end
endmodule

// File: rtl/emmc_init_seq.sv
module emmc_init_seq
    import emmc_init_pkg::*;
#(
    parameter int          MAX_POLL = 1000,
    parameter logic [31:0] OCR_ARG  = 32'h40FF_8080,
    parameter logic [15:0] RCA      = 16'h0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    output logic         cmd_req_o,
    output logic [5:0]   cmd_idx_o,
    output logic [31:0]  cmd_arg_o,
    output logic [1:0]   cmd_rsp_o,
    input  logic         rsp_done_i,
    input  logic         rsp_timeout_i,
    input  logic         rsp_crc_err_i,
    input  logic [127:0] rsp_data_i,
    output logic         ready_o,
    output logic         fail_o,
    output logic [2:0]   err_code_o,
    output logic [31:0]  ocr_o,
    output logic [127:0] cid_o,
    output logic [15:0]  rca_o
);
    seq_state_e state_q, state_d;
    logic       accept;
    logic       poll_last;
    logic       bad_rsp;
    logic       err_set;
    logic [2:0] err_val;
    logic       ld_ocr, ld_cid, ld_rca;

    assign accept  = start_i && (state_q == ST_IDLE || state_q == ST_XFER
                                 || state_q == ST_FAIL);
    assign bad_rsp = rsp_timeout_i || rsp_crc_err_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_code_o <= ERR_NONE;
        else if (accept)  err_code_o <= ERR_NONE;
        else if (err_set) err_code_o <= err_val;
    end

    // next state
    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        err_val = ERR_NONE;
        unique case (state_q)
            ST_IDLE, ST_XFER, ST_FAIL: begin
                if (accept) state_d = ST_RST_SEND;
            end
            ST_RST_SEND: state_d = ST_RST_WAIT;
            ST_RST_WAIT: if (rsp_done_i) state_d = ST_OCR_SEND;
            ST_OCR_SEND: state_d = ST_OCR_WAIT;
            ST_OCR_WAIT: begin
                if (rsp_done_i) begin
                    if (!rsp_timeout_i && rsp_data_i[31]) begin
                        state_d = ST_CID_SEND;
                    end else if (poll_last) begin
                        state_d = ST_FAIL;
                        err_set = 1'b1;
                        err_val = ERR_OCR;
                    end else begin
                        state_d = ST_OCR_SEND;
                    end
                end
            end
            ST_CID_SEND: state_d = ST_CID_WAIT;
            ST_CID_WAIT: begin
                if (rsp_done_i) begin
                    if (bad_rsp) begin
                        state_d = ST_FAIL; err_set = 1'b1; err_val = ERR_CID;
                    end else begin
                        state_d = ST_RCA_SEND;
                    end
                end
            end
            ST_RCA_SEND: state_d = ST_RCA_WAIT;
            ST_RCA_WAIT: begin
                if (rsp_done_i) begin
                    if (bad_rsp) begin
                        state_d = ST_FAIL; err_set = 1'b1; err_val = ERR_RCA;
                    end else begin
                        state_d = ST_SEL_SEND;
                    end
                end
            end
            ST_SEL_SEND: state_d = ST_SEL_WAIT;
            ST_SEL_WAIT: begin
                if (rsp_done_i) begin
                    if (bad_rsp) begin
                        state_d = ST_FAIL; err_set = 1'b1; err_val = ERR_SEL;
                    end else begin
                        state_d = ST_XFER;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_req_o = 1'b0;
        cmd_idx_o = IDX_RST;
        cmd_arg_o = '0;
        cmd_rsp_o = RSP_NONE;
        unique case (state_q)
            ST_RST_SEND, ST_RST_WAIT: begin
                cmd_req_o = (state_q == ST_RST_SEND);
            end
            ST_OCR_SEND, ST_OCR_WAIT: begin
                cmd_req_o = (state_q == ST_OCR_SEND);
                cmd_idx_o = IDX_OCR;
                cmd_arg_o = OCR_ARG;
                cmd_rsp_o = RSP_R3;
            end
            ST_CID_SEND, ST_CID_WAIT: begin
                cmd_req_o = (state_q == ST_CID_SEND);
                cmd_idx_o = IDX_CID;
                cmd_rsp_o = RSP_R2;
            end
            ST_RCA_SEND, ST_RCA_WAIT: begin
                cmd_req_o = (state_q == ST_RCA_SEND);
                cmd_idx_o = IDX_RCA;
                cmd_arg_o = addr_arg(RCA);
                cmd_rsp_o = RSP_R1;
            end
            ST_SEL_SEND, ST_SEL_WAIT: begin
                cmd_req_o = (state_q == ST_SEL_SEND);
                cmd_idx_o = IDX_SEL;
                cmd_arg_o = addr_arg(RCA);
                cmd_rsp_o = RSP_R1;
            end
            default: ;
        endcase
    end

    assign ready_o = (state_q == ST_XFER);
    assign fail_o  = (state_q == ST_FAIL);

    assign ld_ocr = (state_q == ST_OCR_WAIT) && rsp_done_i && !rsp_timeout_i
                    && rsp_data_i[31];
    assign ld_cid = (state_q == ST_CID_WAIT) && rsp_done_i && !bad_rsp;
    assign ld_rca = (state_q == ST_RCA_WAIT) && rsp_done_i && !bad_rsp;

    emmc_poll_ctr #(.MAX_POLL(MAX_POLL)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .inc_i  ((state_q == ST_OCR_WAIT) && rsp_done_i),
        .last_o (poll_last)
    );

    emmc_id_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (accept),
        .ld_ocr_i (ld_ocr),
        .ld_cid_i (ld_cid),
        .ld_rca_i (ld_rca),
        .ocr_d_i  (rsp_data_i[31:0]),
        .cid_d_i  (rsp_data_i),
        .rca_d_i  (RCA),
        .ocr_o    (ocr_o),
        .cid_o    (cid_o),
        .rca_o    (rca_o)
    );

    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o |=> !cmd_req_o);

    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && fail_o));

    a_r10_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && !start_i |=> ready_o);

    a_r10_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o && !start_i |=> fail_o && $stable(err_code_o));

    a_r8_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> err_code_o != ERR_NONE);

    a_r5_ready_ocr: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> ocr_o[31]);

    a_r7_ready_rca: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> rca_o == RCA);

    a_r7_sel_after_rca: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o && cmd_idx_o == IDX_SEL |-> rca_o == RCA);

endmodule

// File: tb/emmc_init_seq_tb.sv
`timescale 1ns/1ps
module emmc_init_seq_tb;
    localparam int          MAXP = 8;
    localparam logic [31:0] OARG = 32'h40FF_8080;
    localparam logic [15:0] ADDR = 16'h0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmd_req;
    logic [5:0] cmd_idx;
    logic [31:0] cmd_arg;
    logic [1:0] cmd_rsp;
    logic rsp_done = 1'b0, spur_done = 1'b0, rsp_to = 1'b0, rsp_crc = 1'b0;
    logic [127:0] rsp_data = '0;
    logic ready, fail;
    logic [2:0] err;
    logic [31:0] ocr;
    logic [127:0] cid;
    logic [15:0] rca;

    always #2.5 clk = ~clk;

    emmc_init_seq #(.MAX_POLL(MAXP), .OCR_ARG(OARG), .RCA(ADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cmd_req_o(cmd_req), .cmd_idx_o(cmd_idx), .cmd_arg_o(cmd_arg),
        .cmd_rsp_o(cmd_rsp), .rsp_done_i(rsp_done | spur_done),
        .rsp_timeout_i(rsp_to), .rsp_crc_err_i(rsp_crc), .rsp_data_i(rsp_data),
        .ready_o(ready), .fail_o(fail), .err_code_o(err),
        .ocr_o(ocr), .cid_o(cid), .rca_o(rca)
    );

    int checks = 0;
    int failures = 0;

    int          n_cmd = 0;
    logic [5:0]  log_idx [0:2047];
    logic [31:0] log_arg [0:2047];
    logic [1:0]  log_typ [0:2047];

    // responder controls
    int           busy_left = 0;
    int           fail_step = 0;
    int           fail_crc = 0;
    logic [31:0]  exp_ocr;
    logic [127:0] exp_cid;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] e_idx(input int k, input int n1);
        if (k == 0) return 6'd0;
        if (k <= n1) return 6'd1;
        if (k == n1 + 1) return 6'd2;
        if (k == n1 + 2) return 6'd3;
        return 6'd7;
    endfunction

    function automatic logic [31:0] e_arg(input logic [5:0] i);
        case (i)
            6'd1: return OARG;
            6'd3, 6'd7: return {ADDR, 16'h0000};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [1:0] e_typ(input logic [5:0] i);
        case (i)
            6'd1: return 2'd3;
            6'd2: return 2'd2;
            6'd3, 6'd7: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // command engine model
    initial begin
        forever begin
            if (cmd_req === 1'b1) begin
                logic [5:0] ci;
                ci = cmd_idx;
                log_idx[n_cmd] = cmd_idx;
                log_arg[n_cmd] = cmd_arg;
                log_typ[n_cmd] = cmd_rsp;
                n_cmd++;
                repeat (1 + $urandom % 4) @(negedge clk);
                rsp_to = 1'b0; rsp_crc = 1'b0; rsp_data = {4{$urandom}};
                if (ci == 6'd0) begin
                    rsp_to = $urandom % 2;
                end else if (ci == 6'd1) begin
                    rsp_crc = $urandom % 2;           // R9: ignored on polls
                    if (busy_left > 0) begin
                        busy_left--;
                        if ($urandom % 4 == 0) begin
                            rsp_to = 1'b1;
                            rsp_data[31:0] = 32'hC0FF_8080; // timeout masks ready bit
                        end else begin
                            rsp_data[31:0] = 32'h40FF_8080;
                        end
                    end else begin
                        rsp_data[31:0] = 32'hC0FF_8000 | ($urandom & 32'hFF);
                        exp_ocr = rsp_data[31:0];
                    end
                end else begin
                    if (ci == 6'd2) exp_cid = rsp_data;
                    if (fail_step == int'(ci)) begin
                        if (fail_crc != 0) rsp_crc = 1'b1;
                        else               rsp_to  = 1'b1;
                    end
                end
                rsp_done = 1'b1;
                @(negedge clk);
                rsp_done = 1'b0; rsp_to = 1'b0; rsp_crc = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_seq(input int busy, input int fstep, input int fcrc,
                           input bit mid_start);
        int base, n1, exp_n, exp_err;
        base = n_cmd;
        busy_left = busy; fail_step = fstep; fail_crc = fcrc;
        @(negedge clk);
        pulse_start();
        if (mid_start) begin
            repeat (3) @(negedge clk);
            pulse_start();                            // R10: ignored while running
        end
        for (int i = 0; i < 3000 && !(ready || fail); i++) @(negedge clk);
        n1 = (busy < MAXP) ? busy + 1 : MAXP;
        exp_err = 0;
        exp_n = 1 + n1 + 3;
        if (busy >= MAXP) begin exp_err = 1; exp_n = 1 + MAXP; end
        else if (fstep == 2) begin exp_err = 2; exp_n = n1 + 2; end
        else if (fstep == 3) begin exp_err = 3; exp_n = n1 + 3; end
        else if (fstep == 7) begin exp_err = 4; exp_n = n1 + 4; end
        if (exp_err == 0) begin
            chk(ready === 1'b1 && fail === 1'b0, "R7 ready", {ready, fail}, 2'b10);
            chk(ocr === exp_ocr, "R5 ocr", ocr, exp_ocr);
            chk(cid === exp_cid, "R6 cid", cid, exp_cid);
            chk(rca === ADDR, "R7 rca", rca, ADDR);
        end else begin
            chk(fail === 1'b1 && ready === 1'b0, exp_err == 1 ? "R4 fail" : "R8 fail",
                {ready, fail}, 2'b01);
            if (exp_err >= 3) chk(cid === exp_cid, "R6 cid kept", cid, exp_cid);
            chk(rca === (exp_err == 4 ? ADDR : 16'h0), "R7 rca on fail", rca,
                exp_err == 4 ? ADDR : 16'h0);
        end
        chk(err === 3'(exp_err), "R8 err_code", err, exp_err);
        chk(n_cmd - base == exp_n, "R11 cmd count", n_cmd - base, exp_n);
        for (int k = 0; k < exp_n && k < n_cmd - base; k++) begin
            logic [5:0] ei;
            ei = e_idx(k, n1);
            chk(log_idx[base+k] === ei && log_arg[base+k] === e_arg(ei)
                && log_typ[base+k] === e_typ(ei), "R2 R3 R6 command",
                {log_idx[base+k], log_arg[base+k], log_typ[base+k]},
                {ei, e_arg(ei), e_typ(ei)});
        end
        // R10: outcome holds, nothing further issued
        base = n_cmd;
        repeat (20) @(negedge clk);
        chk(n_cmd == base, "R10 quiet after end", n_cmd - base, 0);
        chk(ready === (exp_err == 0) && fail === (exp_err != 0), "R10 hold",
            {ready, fail}, {exp_err == 0, exp_err != 0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready === 0 && fail === 0 && err === 0 && cmd_req === 0, "R1 reset flags",
            {ready, fail, err, cmd_req}, 0);
        chk(ocr === 0 && cid === 0 && rca === 0, "R1 reset regs", {ocr, rca}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(n_cmd == 0, "R1 no command without start", n_cmd, 0);

        run_seq(0, 0, 0, 0);                 // plain success
        // R11: stray completion in transfer state ignored
        spur_done = 1'b1; @(negedge clk); spur_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready === 1'b1 && cmd_req === 1'b0, "R11 stray done", ready, 1);
        // R2: restart from transfer state clears stored words
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(ready === 0 && cid === 0 && rca === 0 && ocr === 0, "R2 clear on start",
            {ready, rca}, 0);
        for (int i = 0; i < 400 && !(ready || fail); i++) @(negedge clk);
        repeat (20) @(negedge clk);
        run_seq(MAXP - 1, 0, 0, 0);          // R4: last attempt ready
        run_seq(MAXP, 0, 0, 0);              // R4: budget spent
        run_seq(3, 2, 0, 0);                 // R8 identify timeout
        run_seq(2, 2, 1, 0);                 // R8 identify crc
        run_seq(1, 3, 0, 0);                 // R8 address timeout
        run_seq(0, 3, 1, 0);                 // R8 address crc
        run_seq(2, 7, 0, 0);                 // R8 select timeout
        run_seq(4, 7, 1, 0);                 // R8 select crc
        run_seq(5, 0, 0, 1);                 // R10 start ignored while running
        for (int r = 0; r < 20; r++) begin
            int fs, sel;
            sel = $urandom % 5;
            fs = (sel == 2) ? 2 : (sel == 3) ? 3 : (sel == 4) ? 7 : 0;
            run_seq($urandom % (MAXP + 2), fs, $urandom % 2, $urandom % 2);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule